// File: doc/BRIEF.md
# Array Min/Max Engine

This block is a start/done accelerator that finds the largest and smallest signed 32-bit value in an array held in external memory. The caller presents four 32-bit arguments: the address of the array, the number of elements, and two addresses where the results go. The caller then raises `start`. The engine reads the array over a single-port memory master interface and keeps a running maximum and minimum. It writes the two results back to memory and pulses `done`.

Both running values are seeded from the word at the array address before any comparison takes place. That first word is read even when the element count is zero. A build-time option selects a fast path. The fast path fetches four elements into a small buffer and folds them into the running values in a single step. Any remainder of one to three elements is processed one at a time. The fast path gives exactly the same results as the one-at-a-time path.

Top module: `mmx_engine`

## Requirements
- R1: While `rst_n` is low the engine is idle: `done` and `mem_req` stay low and a high `start` has no effect.
- R2: A new job begins only when `start` is seen high in idle. After `done`, no memory request is made while `start` stays high. `start` must go low before another job can be taken.
- R3: All four arguments are captured in the cycle the job is accepted. Changing them afterwards does not alter the reads or the results.
- R4: Element i is read from base + 4·i. The first read is always at the base address, for the seed. It is followed by reads of elements 0 to count−1 in ascending order, so a job makes count + 1 reads, with at most one request per cycle.
- R5: Comparisons are signed (two's complement). An element replaces the running maximum only if it is strictly greater, and replaces the running minimum only if it is strictly smaller.
- R6: Both results are seeded from the word at the base address. With a count of 0, both written results equal that word.
- R7: An element count whose bit 31 is set (negative) is handled as a count of 0.
- R8: The maximum is written to the max-result address first. In the next cycle the minimum is written to the min-result address. In the cycle after that, `done` is high for exactly one cycle, and the job makes no other writes.
- R9: With `FAST`=1 the engine takes four elements per step while at least four remain, then takes the rest one by one. Its reads and results are identical to those with `FAST`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Job request, level |
| arg_base | input | 32 | Byte address of element 0 |
| arg_count | input | 32 | Element count, signed |
| arg_max_ptr | input | 32 | Byte address for the maximum result |
| arg_min_ptr | input | 32 | Byte address for the minimum result |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, accepted in the same cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The assertions check, on every cycle, the properties that hold across the whole job:
- `done` lasts one cycle and is followed by a quiet memory port.
- The two result writes come back to back, and `done` follows them.
- Every read address sits on the element stride.
- The maximum is never below the minimum when it is written.

Only the bench scenarios can show that the written values are the correct extremes for a given array. The same holds for seeding from the base word on empty and negative counts, ignoring argument changes after acceptance, and the exact read sequence. Bit-for-bit agreement between the fast and the one-at-a-time builds also needs the bench, which runs both builds side by side on the same memory.

// File: rtl/mmx_pkg.sv
// Shared definitions for the array min/max engine.
// Assumes: single-port memory with fixed one-cycle read latency.
package mmx_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DRAIN,
        S_REDUCE,
        S_WMAX,
        S_WMIN,
        S_DONE,
        S_HOLD
    } mmx_state_e;

    // Elements folded per step in the fast path
    localparam int unsigned GROUP = 4;

endpackage

// File: rtl/mmx_args.sv
// Job argument register: captures the four job arguments when a job is accepted
// and clamps a negative element count to zero.
// Assumes: load is a one-cycle strobe issued from idle.
module mmx_args #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [DATA_W-1:0] in_count,
    input  logic [ADDR_W-1:0] in_max_ptr,
    input  logic [ADDR_W-1:0] in_min_ptr,
    output logic [ADDR_W-1:0] base_q,
    output logic [DATA_W-1:0] count_q,
    output logic [ADDR_W-1:0] max_ptr_q,
    output logic [ADDR_W-1:0] min_ptr_q
);

    // Capture arguments at job acceptance; negative count becomes zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            count_q   <= '0;
            max_ptr_q <= '0;
            min_ptr_q <= '0;
        end else if (load) begin
            base_q    <= in_base;
            count_q   <= in_count[DATA_W-1] ? '0 : in_count;
            max_ptr_q <= in_max_ptr;
            min_ptr_q <= in_min_ptr;
        end
    end

endmodule

// File: rtl/mmx_ctrl.sv
// Sequencer: walks a job from acceptance through seed read, element groups,
// two result writes and the done pulse, then waits for start to drop.
// Assumes: memory accepts every request in its cycle; read data arrives one
// cycle after the request.
module mmx_ctrl
    import mmx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter bit          FAST   = 1'b1,
    parameter int unsigned LANES  = GROUP,
    localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned GW    = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] count,
    output logic              load_args,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [LW-1:0]     rd_lane,
    output logic              seed,
    output logic              upd,
    output logic [GW-1:0]     grp_n,
    output logic              wr_max,
    output logic              wr_min,
    output logic              done
);

    mmx_state_e        st;
    logic [ADDR_W-1:0] idx;
    logic [DATA_W-1:0] rem;
    logic [GW-1:0]     grp;
    logic [LW-1:0]     issued;
    logic              seeding;
    logic [DATA_W-1:0] nrem;
    logic [GW-1:0]     next_grp;

    // Remaining elements after the group being folded now
    always_comb nrem = seeding ? count : (rem - DATA_W'(grp));

    // Group size for the next fetch: variant chosen by FAST
    if (FAST) begin : g_fast
        assign next_grp = (nrem >= DATA_W'(LANES)) ? GW'(LANES) : GW'(1);
    end else begin : g_seq
        assign next_grp = GW'(1);
    end

    // Job state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            idx     <= '0;
            rem     <= '0;
            grp     <= GW'(1);
            issued  <= '0;
            seeding <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st      <= S_FETCH;
                    seeding <= 1'b1;
                    idx     <= '0;
                    grp     <= GW'(1);
                    issued  <= '0;
                end
                S_FETCH: begin
                    issued <= issued + 1'b1;
                    idx    <= idx + 1'b1;
                    if (GW'(issued) + GW'(1) == grp) st <= S_DRAIN;
                end
                S_DRAIN: st <= S_REDUCE;
                S_REDUCE: begin
                    seeding <= 1'b0;
                    rem     <= nrem;
                    issued  <= '0;
                    if (seeding) idx <= '0;
                    if (nrem == '0) begin
                        st <= S_WMAX;
                    end else begin
                        grp <= next_grp;
                        st  <= S_FETCH;
                    end
                end
                S_WMAX:  st <= S_WMIN;
                S_WMIN:  st <= S_DONE;
                S_DONE:  st <= start ? S_HOLD : S_IDLE;
                S_HOLD:  if (!start) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Decoded strobes and read address
    always_comb begin
        load_args = (st == S_IDLE) && start;
        rd_req    = (st == S_FETCH);
        rd_addr   = base + (idx << 2);
        rd_lane   = issued;
        seed      = (st == S_REDUCE) && seeding;
        upd       = (st == S_REDUCE) && !seeding;
        grp_n     = grp;
        wr_max    = (st == S_WMAX);
        wr_min    = (st == S_WMIN);
        done      = (st == S_DONE);
    end

endmodule

// File: rtl/mmx_lanes.sv
// Lane buffer: places each returning read word into the lane it was
// fetched for, so a whole group is available for one reduction step.
// Assumes: read data is valid exactly one cycle after rd_req.
module mmx_lanes #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req,
    input  logic [LW-1:0]             rd_lane,
    input  logic [DATA_W-1:0]         rdata,
    output logic [LANES*DATA_W-1:0]   lanes
);

    logic          pend;
    logic [LW-1:0] lane_q;

    // Remember which lane the outstanding read belongs to
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            lane_q <= '0;
        end else begin
            pend   <= rd_req;
            lane_q <= rd_lane;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Capture the returning word into this lane
        always_ff @(posedge clk) begin
            if (!rst_n) lanes[l*DATA_W +: DATA_W] <= '0;
            else if (pend && lane_q == LW'(l)) lanes[l*DATA_W +: DATA_W] <= rdata;
        end
    end

endmodule

// File: rtl/mmx_reduce.sv
// Reduction unit: holds the running maximum and minimum; seeds both from
// lane 0, or folds the first grp lanes in lane order with strict signed tests.
// Assumes: seed and upd are never high together.
module mmx_reduce #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANES  = 4,
    localparam int unsigned GW    = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    seed,
    input  logic                    upd,
    input  logic [GW-1:0]           grp,
    input  logic [LANES*DATA_W-1:0] lanes,
    output logic [DATA_W-1:0]       max_q,
    output logic [DATA_W-1:0]       min_q
);

    logic [DATA_W-1:0] cmax [0:LANES];
    logic [DATA_W-1:0] cmin [0:LANES];

    assign cmax[0] = max_q;
    assign cmin[0] = min_q;

    for (genvar l = 0; l < LANES; l++) begin : g_step
        logic [DATA_W-1:0] v;
        logic              act;
        assign v   = lanes[l*DATA_W +: DATA_W];
        assign act = (GW'(l) < grp);
        assign cmax[l+1] = (act && ($signed(v) > $signed(cmax[l]))) ? v : cmax[l];
        assign cmin[l+1] = (act && ($signed(v) < $signed(cmin[l]))) ? v : cmin[l];
    end

    // Seed or fold the running extremes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            max_q <= '0;
            min_q <= '0;
        end else if (seed) begin
            max_q <= lanes[DATA_W-1:0];
            min_q <= lanes[DATA_W-1:0];
        end else if (upd) begin
            max_q <= cmax[LANES];
            min_q <= cmin[LANES];
        end
    end

endmodule

// File: rtl/mmx_engine.sv
// Array min/max engine top: argument register, sequencer, lane buffer and
// reduction unit sharing one memory master port.
// Assumes: memory accepts each request in its cycle, one-cycle read latency.
module mmx_engine
    import mmx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    parameter bit          FAST   = 1'b1,
    localparam int unsigned LANES = FAST ? GROUP : 1,
    localparam int unsigned LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned GW    = $clog2(LANES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] arg_base,
    input  logic [DATA_W-1:0] arg_count,
    input  logic [ADDR_W-1:0] arg_max_ptr,
    input  logic [ADDR_W-1:0] arg_min_ptr,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic                    load_args;
    logic [ADDR_W-1:0]       base_q;
    logic [DATA_W-1:0]       count_q;
    logic [ADDR_W-1:0]       max_ptr_q;
    logic [ADDR_W-1:0]       min_ptr_q;
    logic                    rd_req;
    logic [ADDR_W-1:0]       rd_addr;
    logic [LW-1:0]           rd_lane;
    logic                    seed;
    logic                    upd;
    logic [GW-1:0]           grp_n;
    logic                    wr_max;
    logic                    wr_min;
    logic [LANES*DATA_W-1:0] lanes;
    logic [DATA_W-1:0]       max_q;
    logic [DATA_W-1:0]       min_q;

    mmx_args #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_args (
        .clk(clk), .rst_n(rst_n), .load(load_args),
        .in_base(arg_base), .in_count(arg_count),
        .in_max_ptr(arg_max_ptr), .in_min_ptr(arg_min_ptr),
        .base_q(base_q), .count_q(count_q),
        .max_ptr_q(max_ptr_q), .min_ptr_q(min_ptr_q)
    );

    mmx_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .FAST(FAST), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base(base_q), .count(count_q),
        .load_args(load_args), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_lane(rd_lane), .seed(seed), .upd(upd), .grp_n(grp_n),
        .wr_max(wr_max), .wr_min(wr_min), .done(done)
    );

    mmx_lanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_lane(rd_lane),
        .rdata(mem_rdata), .lanes(lanes)
    );

    mmx_reduce #(.DATA_W(DATA_W), .LANES(LANES)) u_reduce (
        .clk(clk), .rst_n(rst_n), .seed(seed), .upd(upd), .grp(grp_n),
        .lanes(lanes), .max_q(max_q), .min_q(min_q)
    );

    // Memory port multiplexer: reads from the sequencer, then the two writes
    always_comb begin
        mem_req   = rd_req | wr_max | wr_min;
        mem_we    = wr_max | wr_min;
        mem_addr  = wr_max ? max_ptr_q : (wr_min ? min_ptr_q : rd_addr);
        mem_wdata = wr_max ? max_q : (wr_min ? min_q : '0);
    end

endmodule

// File: rtl/mmx_chk.sv
// Protocol checker for the min/max engine, bound into every instance.
// Assumes: synchronous active-low reset; reads and writes accepted in-cycle.
module mmx_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] base_q,
    input logic [DATA_W-1:0] max_q,
    input logic [DATA_W-1:0] min_q
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req); // R2

    AST_WRITE_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we)); // R8

    AST_WRITE_PAIR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |=> (done && !mem_req)); // R8

    AST_READ_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (((mem_addr - base_q) & ADDR_W'(3)) == '0)); // R4

    AST_MAX_NOT_BELOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($signed(max_q) >= $signed(min_q))); // R5

endmodule

bind mmx_engine mmx_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .base_q(base_q), .max_q(max_q), .min_q(min_q)
);

// File: tb/sim_mmx_engine.sv
`timescale 1ns/1ps
// Bench: runs a fast-path build (u0) and a one-at-a-time build (u1) on the
// same memory image and checks both against reference results.
module sim_mmx_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a_base = '0, a_count = '0, a_max = '0, a_min = '0;
    logic        done  [2];
    logic        req   [2];
    logic        we    [2];
    logic [31:0] addr  [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic [31:0] mem   [64];

    int nchk = 0, nfail = 0;
    logic        clr = 1'b0;
    logic [31:0] job_base = '0;
    int nrd [2], nwr [2], ndone [2], rdbad [2];
    logic [31:0] wa [2][2];
    logic [31:0] wd [2][2];

    always #2.5 clk = ~clk;

    mmx_engine #(.FAST(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_base(a_base),
        .arg_count(a_count), .arg_max_ptr(a_max), .arg_min_ptr(a_min),
        .done(done[0]), .mem_req(req[0]), .mem_we(we[0]), .mem_addr(addr[0]),
        .mem_wdata(wdata[0]), .mem_rdata(rdata[0])
    );

    mmx_engine #(.FAST(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .arg_base(a_base),
        .arg_count(a_count), .arg_max_ptr(a_max), .arg_min_ptr(a_min),
        .done(done[1]), .mem_req(req[1]), .mem_we(we[1]), .mem_addr(addr[1]),
        .mem_wdata(wdata[1]), .mem_rdata(rdata[1])
    );

    // Memory model: one-cycle read latency per port
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++)
            if (req[k] && !we[k]) rdata[k] <= mem[addr[k][7:2]];
    end

    // Port monitor: read sequence, writes and done pulses per instance
    always @(posedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (clr) begin
                nrd[k] = 0; nwr[k] = 0; ndone[k] = 0; rdbad[k] = 0;
            end else if (rst_n) begin
                if (req[k] && !we[k]) begin
                    if (addr[k] != ((nrd[k] == 0) ? job_base : job_base + 32'(4 * (nrd[k] - 1))))
                        rdbad[k]++;
                    nrd[k]++;
                end
                if (req[k] && we[k]) begin
                    if (nwr[k] < 2) begin
                        wa[k][nwr[k]] = addr[k];
                        wd[k][nwr[k]] = wdata[k];
                    end
                    nwr[k]++;
                end
                if (done[k]) ndone[k]++;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Reference extremes for an array of n words at word index b
    function automatic void ref_mm(input int b, input int n, output int mx, output int mn);
        mx = $signed(mem[b]);
        mn = mx;
        for (int i = 0; i < n; i++) begin
            if ($signed(mem[b + i]) > mx) mx = $signed(mem[b + i]);
            if ($signed(mem[b + i]) < mn) mn = $signed(mem[b + i]);
        end
    endfunction

    // One job on both instances, with argument scrambling after acceptance (R3)
    task automatic run_job(input int bidx, input int cnt, input int jid);
        int mx, mn, eff, wait_c;
        logic [31:0] pmx, pmn;
        eff = (cnt < 0) ? 0 : cnt;
        ref_mm(bidx, eff, mx, mn);
        pmx = 32'h1000 + 32'(jid * 8);
        pmn = 32'h2000 + 32'(jid * 8);
        @(negedge clk);
        clr = 1'b1;
        job_base = 32'(bidx * 4);
        a_base = 32'(bidx * 4); a_count = 32'(cnt); a_max = pmx; a_min = pmn;
        @(negedge clk);
        clr = 1'b0;
        start = 1'b1;
        @(negedge clk);
        a_base = $urandom; a_count = 32'd3; a_max = $urandom; a_min = $urandom;
        wait_c = 0;
        while ((ndone[0] == 0 || ndone[1] == 0) && wait_c < 1000) begin
            @(negedge clk);
            wait_c++;
        end
        chk(wait_c < 1000, "R8 done timeout", wait_c, 0);
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(nwr[k] == 2, "R8 write count", nwr[k], 2);
            chk(wa[k][0] == pmx, "R8 max address R3", wa[k][0], pmx);
            chk(wa[k][1] == pmn, "R8 min address R3", wa[k][1], pmn);
            chk($signed(wd[k][0]) == mx, "R5 R6 R7 R9 max value", wd[k][0], 32'(mx));
            chk($signed(wd[k][1]) == mn, "R5 R6 R7 R9 min value", wd[k][1], 32'(mn));
            chk(nrd[k] == eff + 1, "R4 R7 read count R2", nrd[k], eff + 1);
            chk(rdbad[k] == 0, "R4 read order", rdbad[k], 0);
            chk(ndone[k] == 1, "R8 R2 single done", ndone[k], 1);
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) mem[i] = $urandom;
        // R1: reset holds the engine idle even with start high
        start = 1'b1;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(done[k] == 1'b0, "R1 done in reset", done[k], 0);
            chk(req[k] == 1'b0, "R1 req in reset", req[k], 0);
        end
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++)
            chk(req[k] == 1'b0 && done[k] == 1'b0, "R1 idle after reset", req[k], 0);
        // R6: empty array seeds from base word
        run_job(5, 0, 0);
        // R7: negative count acts as zero
        run_job(9, -5, 1);
        run_job(2, 32'h8000_0000, 2);
        // R5: equal values, strict compare keeps first
        for (int i = 0; i < 6; i++) mem[20 + i] = 32'hFFFF_FFF0;
        run_job(20, 6, 3);
        // R5: signed extremes
        mem[30] = 32'h0000_0001; mem[31] = 32'h8000_0000; mem[32] = 32'h7FFF_FFFF;
        mem[33] = 32'hFFFF_FFFF; mem[34] = 32'h0; mem[35] = 32'h8000_0001;
        mem[36] = 32'h7FFF_FFFE; mem[37] = 32'h5; mem[38] = 32'hFFFF_FFFE;
        run_job(30, 9, 4);
        // R9: ascending and descending runs of 20
        for (int i = 0; i < 20; i++) mem[40 + i] = 32'(i * 100 - 900);
        run_job(40, 20, 5);
        for (int i = 0; i < 20; i++) mem[40 + i] = 32'(900 - i * 100);
        run_job(40, 20, 6);
        // R9: group/tail boundaries
        for (int c = 1; c <= 9; c++) begin
            for (int i = 0; i < 64; i++) mem[i] = $urandom;
            run_job(c * 3, c, 7 + c);
        end
        // Random jobs
        for (int j = 0; j < 30; j++) begin
            for (int i = 0; i < 64; i++) mem[i] = $urandom;
            run_job(int'($urandom_range(0, 40)), int'($urandom_range(0, 20)), 20 + j);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(5.0 * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule